// File: doc/BRIEF.md
# Serial Converter Output Port Sequencer

This block is the digital control for the three-wire read-out port of a 12-bit sampling converter. It runs on a fast system clock and watches two pins from the host: an active-low chip select and a shift clock. Both pass through two-flop synchronizers, and their edges are detected in the system-clock domain. A falling chip select opens a frame. The block captures the converter's 12-bit result, puts the sampler into hold and starts driving the serial data pin. Each shift-clock falling edge then moves the pin on by one bit. A full frame holds sixteen bit slots: two zeros, the result MSB first, then two more zeros.

Power state is controlled only by where in the frame the chip select rises. A rise in the early-middle part of the frame puts the port to sleep. A rise later in the frame only cuts the frame short. Out of reset the port is asleep. A full dummy frame wakes it, and the data in that frame is not valid. A one-cycle strobe marks the moment a result finishes converting in a frame that began powered. The strobe has no ready signal and cannot be held off, because the host's shift clock cannot be stalled, so a consumer must take it in the cycle it appears.

Top module: `adc_serial_port`

## Requirements
- R1: While reset is held, the data output enable is 0, the sample/hold control is 1 (hold), the powered flag is 0 and the result strobe is 0.
- R2: Within three system-clock cycles of chip select going low, the output enable is 1, the data pin is 0 (first leading zero) and the sample/hold is in hold.
- R3: After shift-clock falling edge n of a frame, the data pin shows 0 for n = 1, result bit 13-n for n = 2..13 (n = 2 gives bit 11, the MSB; n = 13 gives bit 0), and 0 for n = 14 and 15.
- R4: In a frame started while powered, the result strobe is high for exactly one system cycle, issued at the 13th falling edge. It never fires in a wake-up frame or in a frame cut short before that edge.
- R5: In a frame started while powered, the sample/hold stays in hold through the 13th falling edge and returns to sample (0) at the 14th.
- R6: The output enable drops at the 16th falling edge. Further shift-clock edges while chip select remains low do not re-enable it.
- R7: Chip select going high during a frame drops the output enable within three system cycles. While chip select is high the output stays disabled.
- R8: Chip select rising after falling edge 2 through 9 (count 2..9 inclusive) clears the powered flag and sets hold.
- R9: Chip select rising after falling edge 10 through 15 of a powered frame leaves the port powered with the sampler in sample mode and the output disabled.
- R10: In sleep, a frame moves the sampler to sample mode at its 1st falling edge and raises the powered flag at its 16th. No result strobe is issued.
- R11: Shift-clock edges while chip select is high change no output.
- R12: Chip select rising before the 2nd falling edge leaves the powered flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the shift clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| sclk | input | 1 | Host shift clock, asynchronous |
| conv_result | input | 12 | Result word from the converter model, captured at frame start |
| sdo | output | 1 | Serial data bit (0 when disabled) |
| sdo_oe | output | 1 | Serial data output enable |
| sh_hold | output | 1 | Sample/hold control, 1 = hold |
| powered | output | 1 | 1 when the port is fully powered up |
| result_valid | output | 1 | One-cycle strobe at conversion completion |

## Verification
The assertions assume that each chip-select and shift-clock level lasts at least three system cycles. They also assume a chip-select edge and a shift-clock falling edge never arrive in the same synchronized cycle, and that the converter result is steady when chip select falls. The stimulus holds every level for four system cycles and moves chip select only while the shift clock sits low and idle. It steps frames through every power-state boundary: counts 1, 2, 9, 10 and 11 for the chip-select rise, wake-up from sleep, and two differing result words.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;
  // Frame events that the sequencer derives each system cycle
  typedef struct packed {
    logic start;  // chip select fell
    logic adv;    // shift clock fell inside an open frame
    logic abort;  // chip select rose inside an open frame
  } frame_ev_t;
endpackage

// File: rtl/adcsp_sync_edge.sv
module adcsp_sync_edge #(
  parameter int           W       = 2,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= chain[STAGES-1];
  end

  assign lvl_o  = chain[STAGES-1];
  assign rise_o = chain[STAGES-1] & ~prev_q;
  assign fall_o = ~chain[STAGES-1] & prev_q;
endmodule

// File: rtl/adcsp_frame_seq.sv
module adcsp_frame_seq
  import adcsp_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sck_fall,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o,
  output frame_ev_t        ev_o,
  output logic [CNT_W-1:0] ev_idx_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx = cnt_q + CNT_W'(1);

  always_comb begin
    ev_o.start = cs_fall;
    ev_o.abort = cs_rise & active_q;
    ev_o.adv   = sck_fall & active_q & ~cs_rise & ~cs_fall;
    ev_idx_o   = ev_o.abort ? cnt_q : cnt_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (cs_rise) begin
      active_q <= 1'b0;
    end else if (cs_fall) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (ev_o.adv) begin
      cnt_q <= cnt_nx;
      if (cnt_nx == LAST) active_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign cnt_o    = cnt_q;

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_closed_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LAST) |-> !active_q);
endmodule

// File: rtl/adcsp_power_ctl.sv
module adcsp_power_ctl
  import adcsp_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int FRAME_LEN   = 16,
  parameter int DONE_AT     = 13,
  parameter int SAMPLE_AT   = 14,
  parameter int SLEEP_FIRST = 2,
  parameter int SLEEP_LAST  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  frame_ev_t        ev_i,
  input  logic [CNT_W-1:0] ev_idx_i,
  output logic             powered_o,
  output logic             hold_o,
  output logic             valid_o
);
  localparam logic [CNT_W-1:0] K_DONE   = CNT_W'(DONE_AT);
  localparam logic [CNT_W-1:0] K_SAMPLE = CNT_W'(SAMPLE_AT);
  localparam logic [CNT_W-1:0] K_LAST   = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] K_SLP_LO = CNT_W'(SLEEP_FIRST);
  localparam logic [CNT_W-1:0] K_SLP_HI = CNT_W'(SLEEP_LAST);
  localparam logic [CNT_W-1:0] K_ONE    = CNT_W'(1);

  logic powered_q, hold_q, wake_q, valid_q;
  logic in_sleep_window;

  assign in_sleep_window = (ev_idx_i >= K_SLP_LO) && (ev_idx_i <= K_SLP_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      powered_q <= 1'b0;
      hold_q    <= 1'b1;
      wake_q    <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (ev_i.start) begin
        hold_q <= 1'b1;
        wake_q <= !powered_q;
      end else if (ev_i.adv) begin
        if (!wake_q && ev_idx_i == K_DONE)   valid_q <= 1'b1;
        if (!wake_q && ev_idx_i == K_SAMPLE) hold_q  <= 1'b0;
        if (wake_q && ev_idx_i == K_ONE)     hold_q  <= 1'b0;
        if (wake_q && ev_idx_i == K_LAST) begin
          powered_q <= 1'b1;
          wake_q    <= 1'b0;
        end
      end else if (ev_i.abort) begin
        wake_q <= 1'b0;
        if (in_sleep_window) begin
          powered_q <= 1'b0;
          hold_q    <= 1'b1;
        end else begin
          hold_q <= !powered_q;
        end
      end
    end
  end

  assign powered_o = powered_q;
  assign hold_o    = hold_q;
  assign valid_o   = valid_q;

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  assert_sleep_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!powered_q && !wake_q) |-> hold_q);
  assert_no_strobe_waking_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> !valid_q);
endmodule

// File: rtl/adcsp_shift_out.sv
module adcsp_shift_out
  import adcsp_pkg::*;
#(
  parameter int RES_W     = 12,
  parameter int LEAD_Z    = 2,
  parameter int FRAME_LEN = 16,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  frame_ev_t        ev_i,
  input  logic [CNT_W-1:0] ev_idx_i,
  input  logic [RES_W-1:0] word_i,
  output logic             sdo_o,
  output logic             oe_o
);
  localparam logic [CNT_W-1:0] K_LAST = CNT_W'(FRAME_LEN);

  logic [RES_W-1:0] word_q;
  logic [RES_W-1:0] shifted;
  logic             bit_sel;
  int unsigned      pos;
  logic             sdo_q, oe_q;

  always_comb begin
    pos     = int'(ev_idx_i);
    shifted = '0;
    bit_sel = 1'b0;
    if (pos >= LEAD_Z && pos < LEAD_Z + RES_W) begin
      shifted = word_q << (pos - LEAD_Z);
      bit_sel = shifted[RES_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      sdo_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else if (ev_i.start) begin
      word_q <= word_i;
      sdo_q  <= 1'b0;
      oe_q   <= 1'b1;
    end else if (ev_i.abort) begin
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (ev_i.adv) begin
      if (ev_idx_i == K_LAST) begin
        sdo_q <= 1'b0;
        oe_q  <= 1'b0;
      end else begin
        sdo_q <= bit_sel;
      end
    end
  end

  assign sdo_o = sdo_q & oe_q;
  assign oe_o  = oe_q;
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adcsp_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int LEAD_Z      = 2,
  parameter int TRAIL_Z     = 2,
  parameter int SLEEP_FIRST = 2,
  parameter int SLEEP_LAST  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic [RES_W-1:0] conv_result,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             sh_hold,
  output logic             powered,
  output logic             result_valid
);
  localparam int FRAME_LEN = LEAD_Z + RES_W + TRAIL_Z;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int DONE_AT   = LEAD_Z + RES_W - 1;
  localparam int SAMPLE_AT = DONE_AT + 1;

  logic [1:0] pin_lvl, pin_rise, pin_fall;
  logic             active;
  logic [CNT_W-1:0] fall_cnt, ev_idx;
  frame_ev_t        ev;

  adcsp_sync_edge #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i({cs_n, sclk}),
    .lvl_o(pin_lvl), .rise_o(pin_rise), .fall_o(pin_fall)
  );

  adcsp_frame_seq #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cs_fall(pin_fall[1]), .cs_rise(pin_rise[1]), .sck_fall(pin_fall[0]),
    .active_o(active), .cnt_o(fall_cnt), .ev_o(ev), .ev_idx_o(ev_idx)
  );

  adcsp_power_ctl #(
    .CNT_W(CNT_W), .FRAME_LEN(FRAME_LEN), .DONE_AT(DONE_AT), .SAMPLE_AT(SAMPLE_AT),
    .SLEEP_FIRST(SLEEP_FIRST), .SLEEP_LAST(SLEEP_LAST)
  ) u_pwr (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .ev_idx_i(ev_idx),
    .powered_o(powered), .hold_o(sh_hold), .valid_o(result_valid)
  );

  adcsp_shift_out #(
    .RES_W(RES_W), .LEAD_Z(LEAD_Z), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)
  ) u_out (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .ev_idx_i(ev_idx),
    .word_i(conv_result), .sdo_o(sdo), .oe_o(sdo_oe)
  );

  assert_release_on_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && pin_lvl[1]) |=> !sdo_oe);
  assert_pad_zeros_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && (fall_cnt < CNT_W'(LEAD_Z) || fall_cnt > CNT_W'(DONE_AT))) |-> !sdo);
  assert_powerup_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(powered) |-> (fall_cnt == CNT_W'(FRAME_LEN)));
  assert_oe_needs_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> active);
endmodule

// File: tb/tb_adc_serial_port.sv
module tb_adc_serial_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n;
  logic        sclk;
  logic [11:0] conv_result;
  logic        sdo, sdo_oe, sh_hold, powered, result_valid;

  int checks = 0;
  int fails  = 0;
  int strobes = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  adc_serial_port dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .conv_result(conv_result),
    .sdo(sdo), .sdo_oe(sdo_oe), .sh_hold(sh_hold), .powered(powered),
    .result_valid(result_valid)
  );

  always @(posedge clk) if (result_valid) strobes++;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cs(input logic v);
    cs_n = v;
    tick(4);
  endtask

  task automatic sck_pulse();
    sclk = 1'b1; tick(4);
    sclk = 1'b0; tick(4);
  endtask

  function automatic int exp_bit(input logic [11:0] d, input int n);
    if (n >= 2 && n <= 13) return int'(d[13 - n]);
    return 0;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; conv_result = '0;
    tick(5);
    check("R1 oe", int'(sdo_oe), 0);
    check("R1 hold", int'(sh_hold), 1);
    check("R1 powered", int'(powered), 0);
    check("R1 valid", int'(result_valid), 0);
    rst_n = 1'b1;
    tick(4);
  endtask

  task automatic t_idle_sclk();
    int hold0 = int'(sh_hold);
    int pwr0  = int'(powered);
    for (int i = 0; i < 5; i++) sck_pulse();
    check("R11 oe", int'(sdo_oe), 0);
    check("R11 hold", int'(sh_hold), hold0);
    check("R11 powered", int'(powered), pwr0);
  endtask

  task automatic t_wake();
    int s0 = strobes;
    conv_result = 12'hFFF;
    set_cs(1'b0);
    check("R2 oe wake", int'(sdo_oe), 1);
    check("R10 hold asleep", int'(sh_hold), 1);
    sck_pulse();
    check("R10 sample at 1st", int'(sh_hold), 0);
    for (int n = 2; n <= 15; n++) sck_pulse();
    check("R10 not yet powered", int'(powered), 0);
    sck_pulse();
    check("R10 powered at 16th", int'(powered), 1);
    check("R10 no strobe", strobes - s0, 0);
    check("R6 oe after 16", int'(sdo_oe), 0);
    set_cs(1'b1);
  endtask

  task automatic t_frame(input logic [11:0] d);
    int s0 = strobes;
    conv_result = d;
    set_cs(1'b0);
    check("R2 oe", int'(sdo_oe), 1);
    check("R2 sdo", int'(sdo), 0);
    check("R2 hold", int'(sh_hold), 1);
    conv_result = ~d;
    for (int n = 1; n <= 16; n++) begin
      sck_pulse();
      if (n <= 15) check($sformatf("R3 bit n=%0d", n), int'(sdo), exp_bit(d, n));
      if (n == 12) check("R4 no early strobe", strobes - s0, 0);
      if (n == 13) begin
        check("R4 one strobe cycle", strobes - s0, 1);
        check("R5 hold at 13", int'(sh_hold), 1);
      end
      if (n == 14) check("R5 sample at 14", int'(sh_hold), 0);
      if (n == 16) check("R6 oe off at 16", int'(sdo_oe), 0);
    end
    sck_pulse();
    check("R6 stays off", int'(sdo_oe), 0);
    check("R4 total strobes", strobes - s0, 1);
    set_cs(1'b1);
  endtask

  task automatic t_cut(input int falls, input int exp_pwr, input int exp_hold, input string req);
    int s0 = strobes;
    conv_result = 12'h5A5;
    set_cs(1'b0);
    for (int n = 1; n <= falls; n++) sck_pulse();
    cs_n = 1'b1;
    tick(3);
    check("R7 oe released", int'(sdo_oe), 0);
    tick(1);
    check({req, " powered"}, int'(powered), exp_pwr);
    check({req, " hold"}, int'(sh_hold), exp_hold);
    if (falls < 13) check({req, " no strobe"}, strobes - s0, 0);
    sck_pulse();
    check("R7 oe stays off", int'(sdo_oe), 0);
  endtask

  initial begin
    t_reset();
    t_idle_sclk();
    t_wake();
    t_frame(12'hA5C);
    t_frame(12'h3F1);
    t_idle_sclk();
    t_cut(11, 1, 0, "R9 cut 11");
    t_cut(10, 1, 0, "R9 cut 10");
    t_cut(1, 1, 0, "R12 cut 1");
    t_frame(12'h801);
    t_cut(2, 0, 1, "R8 cut 2");
    t_idle_sclk();
    t_cut(1, 0, 1, "R12 cut 1 asleep");
    t_wake();
    t_cut(9, 0, 1, "R8 cut 9");
    t_wake();
    t_frame(12'h001);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule